// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block places a 32x32 pointer image on top of a raster RGB pixel stream. Each image cell holds a two-bit code. Depending on that code and a mode bit, the cell shows one of two programmed cursor colours, shows an auxiliary colour, lets the input pixel through, or shows the bit-inverted input pixel. Pixels outside the cursor window pass through unchanged. Every pixel goes through the same two-register pipeline, so the output stream is the input stream delayed by a fixed amount.

A host write port loads the 256-byte image store and a small set of registers: screen position, hot-spot offset, three colours and the mode bit. Every host write goes to a back copy. The back copy moves to the live copy on the first pixel of the next frame, so a cursor change never tears part way down the screen. The stream carries a frame-start strobe and a line-start strobe. The block derives the pixel coordinates from these strobes and from the pixel-valid signal.

Top module: `curs_overlay`

## Requirements
- R1: While reset is held low and right after it, `out_valid` is 0 and `out_rgb` is 0.
- R2: A pixel presented with `in_valid`=1 appears on `out_rgb` with `out_valid`=1 two clock cycles later. A cycle with `in_valid`=0 yields `out_valid`=0 two cycles later.
- R3: A valid pixel with `in_sof`=1 has coordinate (0,0). A valid pixel with `in_sol`=1 (and `in_sof`=0) has x=0 and a y one above the previous line. Every other valid pixel has the previous valid pixel's x plus 1 on the same line. Idle cycles do not advance the coordinates.
- R4: The window origin on each axis is the position minus the hot-spot offset, or 0 if that difference would be negative. The window covers 32 columns and 32 rows from the origin and may run past the right and bottom frame edges. Pixels outside the window leave unchanged.
- R5: Host address a below 256 writes `hw_data[7:0]` into image byte a. That byte serves image row a[7:3] and columns 4*a[2:0] to 4*a[2:0]+3. Column 4*a[2:0]+k uses bits [2k+1:2k].
- R6: Inside the window, code 00 outputs colour 2, code 01 outputs colour 1, and code 10 outputs the input pixel.
- R7: Code 11 with mode 0 outputs the input pixel with all 24 bits complemented. The R, G and B components sit at bits [23:16], [15:8] and [7:0].
- R8: Code 11 with mode 1 outputs the auxiliary colour.
- R9: The register addresses are as follows:
  - 256: x position in `hw_data[11:0]`.
  - 257: y position in `hw_data[11:0]`.
  - 258: hot-spot x in `hw_data[4:0]` and hot-spot y in `hw_data[20:16]`.
  - 259: colour 1.
  - 260: colour 2.
  - 261: auxiliary colour.
  - 262: mode in `hw_data[0]`.

  A register or image write made during a frame has no effect on that frame. It applies from the next valid pixel with `in_sof`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_en | input | 1 | Host write strobe |
| hw_addr | input | 9 | Host write address (image bytes, then registers) |
| hw_data | input | 24 | Host write data |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame (with in_valid) |
| in_sol | input | 1 | First pixel of a line (with in_valid) |
| in_rgb | input | 24 | Input pixel, R in [23:16], G in [15:8], B in [7:0] |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Output pixel |

## Verification
Every result is due exactly two rising edges after its pixel is driven. The bench therefore keeps a two-deep queue of expected pixels, and at each falling edge it compares the outputs with the entry driven two falling edges earlier. Host writes take effect at the frame boundary. The reference model copies its back registers to its live registers when it issues the next start-of-frame pixel. It then checks every pixel of the frame in which a mid-frame write occurred against the old settings.

// File: rtl/curs_pkg.sv
package curs_pkg;
   localparam logic [2:0] REG_POSX = 3'd0;
   localparam logic [2:0] REG_POSY = 3'd1;
   localparam logic [2:0] REG_HOT  = 3'd2;
   localparam logic [2:0] REG_COL1 = 3'd3;
   localparam logic [2:0] REG_COL2 = 3'd4;
   localparam logic [2:0] REG_AUX  = 3'd5;
   localparam logic [2:0] REG_MODE = 3'd6;

   typedef enum logic [1:0] {
      CODE_COL2 = 2'b00,
      CODE_COL1 = 2'b01,
      CODE_PASS = 2'b10,
      CODE_SPCL = 2'b11
   } curs_code_e;
endpackage

// File: rtl/curs_cfg.sv
module curs_cfg
   import curs_pkg::*;
#(
   parameter int CRDW = 12,
   parameter int CW   = 24,
   parameter int DIM  = 32,
   localparam int HW   = $clog2(DIM),
   localparam int NB   = DIM * DIM / 4,
   localparam int IDXW = $clog2(NB),
   localparam int AW   = IDXW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [CW-1:0]   wr_data,
   input  logic            swap,
   input  logic [IDXW-1:0] rd_idx,
   output logic [7:0]      rd_byte,
   output logic [CRDW-1:0] pos_x,
   output logic [CRDW-1:0] pos_y,
   output logic [HW-1:0]   hot_x,
   output logic [HW-1:0]   hot_y,
   output logic [CW-1:0]   col1,
   output logic [CW-1:0]   col2,
   output logic [CW-1:0]   aux,
   output logic            mode
);
   logic [CRDW-1:0] bk_px, bk_py;
   logic [HW-1:0]   bk_hx, bk_hy;
   logic [CW-1:0]   bk_c1, bk_c2, bk_aux;
   logic            bk_mode;
   logic [7:0]      bk_img [NB];
   logic [7:0]      lv_img [NB];

   wire reg_wr = wr_en && wr_addr[AW-1];
   wire img_wr = wr_en && !wr_addr[AW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bk_px <= '0; bk_py <= '0; bk_hx <= '0; bk_hy <= '0;
         bk_c1 <= '0; bk_c2 <= '0; bk_aux <= '0; bk_mode <= 1'b0;
      end else if (reg_wr) begin
         case (wr_addr[2:0])
            REG_POSX: bk_px   <= wr_data[CRDW-1:0];
            REG_POSY: bk_py   <= wr_data[CRDW-1:0];
            REG_HOT: begin
               bk_hx <= wr_data[HW-1:0];
               bk_hy <= wr_data[16 +: HW];
            end
            REG_COL1: bk_c1   <= wr_data;
            REG_COL2: bk_c2   <= wr_data;
            REG_AUX:  bk_aux  <= wr_data;
            REG_MODE: bk_mode <= wr_data[0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_x <= '0; pos_y <= '0; hot_x <= '0; hot_y <= '0;
         col1 <= '0; col2 <= '0; aux <= '0; mode <= 1'b0;
      end else if (swap) begin
         pos_x <= bk_px; pos_y <= bk_py; hot_x <= bk_hx; hot_y <= bk_hy;
         col1 <= bk_c1; col2 <= bk_c2; aux <= bk_aux; mode <= bk_mode;
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bk_img[b] <= '0;
            lv_img[b] <= '0;
         end else begin
            if (img_wr && wr_addr[IDXW-1:0] == IDXW'(b)) bk_img[b] <= wr_data[7:0];
            if (swap) lv_img[b] <= bk_img[b];
         end
      end
   end

   assign rd_byte = lv_img[rd_idx];

   // R9
   live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !swap |=> $stable(pos_x) && $stable(pos_y) && $stable(col1) && $stable(mode));
endmodule

// File: rtl/curs_pos.sv
module curs_pos #(
   parameter int CRDW = 12,
   parameter int DIM  = 32,
   localparam int HW  = $clog2(DIM)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            in_sof,
   input  logic            in_sol,
   input  logic [CRDW-1:0] pos_x,
   input  logic [CRDW-1:0] pos_y,
   input  logic [HW-1:0]   hot_x,
   input  logic [HW-1:0]   hot_y,
   output logic            hit,
   output logic [HW-1:0]   row,
   output logic [HW-1:0]   col
);
   logic [CRDW-1:0] x_nxt, y_cur, cur_x, cur_y, s1_x, s1_y;
   logic [CRDW-1:0] hx_w, hy_w, org_x, org_y, dx, dy;

   always_comb begin
      cur_x = (in_sof || in_sol) ? '0 : x_nxt;
      if (in_sof)      cur_y = '0;
      else if (in_sol) cur_y = y_cur + 1'b1;
      else             cur_y = y_cur;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_nxt <= '0; y_cur <= '0; s1_x <= '0; s1_y <= '0;
      end else if (in_valid) begin
         x_nxt <= cur_x + 1'b1;
         y_cur <= cur_y;
         s1_x  <= cur_x;
         s1_y  <= cur_y;
      end
   end

   always_comb begin
      hx_w  = CRDW'(hot_x);
      hy_w  = CRDW'(hot_y);
      org_x = (pos_x >= hx_w) ? pos_x - hx_w : '0;
      org_y = (pos_y >= hy_w) ? pos_y - hy_w : '0;
      dx    = s1_x - org_x;
      dy    = s1_y - org_y;
      hit   = (s1_x >= org_x) && (s1_y >= org_y) &&
              (dx < CRDW'(DIM)) && (dy < CRDW'(DIM));
      row   = dy[HW-1:0];
      col   = dx[HW-1:0];
   end

   logic started;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else if (in_valid && (in_sof || in_sol)) started <= 1'b1;
   end

   // R3
   sof_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_sof |=> s1_x == '0 && s1_y == '0);
   // R3
   x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      started && in_valid && !in_sof && !in_sol |=> s1_x == $past(s1_x) + 1'b1);
endmodule

// File: rtl/curs_overlay.sv
module curs_overlay
   import curs_pkg::*;
#(
   parameter int CRDW = 12,
   parameter int CW   = 24,
   parameter int DIM  = 32,
   localparam int HW   = $clog2(DIM),
   localparam int NB   = DIM * DIM / 4,
   localparam int IDXW = $clog2(NB),
   localparam int AW   = IDXW + 1,
   localparam int NCMP = 3,
   localparam int CMPW = CW / NCMP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hw_en,
   input  logic [AW-1:0] hw_addr,
   input  logic [CW-1:0] hw_data,
   input  logic          in_valid,
   input  logic          in_sof,
   input  logic          in_sol,
   input  logic [CW-1:0] in_rgb,
   output logic          out_valid,
   output logic [CW-1:0] out_rgb
);
   if ((1 << HW) != DIM || DIM < 4) begin : g_bad_dim
      $error("curs_overlay: DIM must be a power of two of at least 4");
   end
   if (CW % NCMP != 0 || CW < 16 + HW || CW < CRDW) begin : g_bad_cw
      $error("curs_overlay: CW must split in three and hold the host fields");
   end
   if (CRDW <= HW) begin : g_bad_crd
      $error("curs_overlay: CRDW must exceed the cursor index width");
   end

   logic [CRDW-1:0] pos_x, pos_y;
   logic [HW-1:0]   hot_x, hot_y, row, col;
   logic [CW-1:0]   col1, col2, aux, s1_rgb, inv_rgb, mix;
   logic            mode, hit, s1_v;
   logic [7:0]      rd_byte;
   logic [1:0]      code;
   wire             swap = in_valid && in_sof;

   curs_cfg #(.CRDW(CRDW), .CW(CW), .DIM(DIM)) u_cfg (
      .clk, .rst_n, .wr_en(hw_en), .wr_addr(hw_addr), .wr_data(hw_data),
      .swap, .rd_idx({row, col[HW-1:2]}), .rd_byte,
      .pos_x, .pos_y, .hot_x, .hot_y, .col1, .col2, .aux, .mode);

   curs_pos #(.CRDW(CRDW), .DIM(DIM)) u_pos (
      .clk, .rst_n, .in_valid, .in_sof, .in_sol,
      .pos_x, .pos_y, .hot_x, .hot_y, .hit, .row, .col);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v <= 1'b0; s1_rgb <= '0;
      end else begin
         s1_v <= in_valid;
         if (in_valid) s1_rgb <= in_rgb;
      end
   end

   for (genvar c = 0; c < NCMP; c++) begin : g_inv
      assign inv_rgb[c*CMPW +: CMPW] = ~s1_rgb[c*CMPW +: CMPW];
   end

   assign code = rd_byte[{col[1:0], 1'b0} +: 2];

   always_comb begin
      mix = s1_rgb;
      if (hit) begin
         case (code)
            CODE_COL2: mix = col2;
            CODE_COL1: mix = col1;
            CODE_PASS: mix = s1_rgb;
            default:   mix = mode ? aux : inv_rgb;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0; out_rgb <= '0;
      end else begin
         out_valid <= s1_v;
         out_rgb   <= mix;
      end
   end

   // R2
   lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));
endmodule

// File: tb/sim_curs_overlay.sv
`timescale 1ns/1ps
module sim_curs_overlay;
   logic clk = 1'b0, rst_n = 1'b0;
   logic hw_en = 1'b0; logic [8:0] hw_addr = '0; logic [23:0] hw_data = '0;
   logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0; logic [23:0] in_rgb = '0;
   logic out_valid; logic [23:0] out_rgb;
   int n_chk = 0, n_bad = 0; bit done = 0;

   always #10 clk = ~clk;

   curs_overlay u0 (.clk, .rst_n, .hw_en, .hw_addr, .hw_data, .in_valid, .in_sof,
      .in_sol, .in_rgb, .out_valid, .out_rgb);

   // reference state: back and live copies
   logic [7:0] bb [256]; logic [7:0] lb [256];
   int b_px, b_py, b_hx, b_hy, l_px, l_py, l_hx, l_hy;
   logic [23:0] b_c1, b_c2, b_ax, l_c1, l_c2, l_ax; bit b_md, l_md;
   int m_x, m_y;
   bit e1v, e2v; logic [23:0] e1, e2; string t1, t2, tag_x;

   task automatic chk(bit ok, string req, logic [23:0] act, logic [23:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_wr(int a, logic [23:0] d);
      if (a < 256) bb[a] = d[7:0];
      else case (a - 256)
         0: b_px = int'(d[11:0]); 1: b_py = int'(d[11:0]);
         2: begin b_hx = int'(d[4:0]); b_hy = int'(d[20:16]); end
         3: b_c1 = d; 4: b_c2 = d; 5: b_ax = d; 6: b_md = d[0];
         default: ;
      endcase
   endtask

   // one cycle: check output due now, then drive the next inputs
   task automatic step(bit v, bit sof, bit sol, logic [23:0] rgb,
                       bit we, int wa, logic [23:0] wd);
      logic [23:0] ex; string tg; int ox, oy, rx, ry, cd;
      @(negedge clk);
      if (e2v) chk(out_valid === 1'b1 && out_rgb === e2, t2, out_rgb, e2);
      else     chk(out_valid === 1'b0, "R2 idle", {23'd0, out_valid}, 24'd0);
      e2v = e1v; e2 = e1; t2 = t1;
      ex = rgb; tg = "R2";
      if (v) begin
         if (sof) begin
            lb = bb; l_px = b_px; l_py = b_py; l_hx = b_hx; l_hy = b_hy;
            l_c1 = b_c1; l_c2 = b_c2; l_ax = b_ax; l_md = b_md;
            m_x = 0; m_y = 0;
         end else if (sol) begin m_x = 0; m_y++; end
         ox = (l_px >= l_hx) ? l_px - l_hx : 0;
         oy = (l_py >= l_hy) ? l_py - l_hy : 0;
         tg = {"R4", tag_x};
         if (m_x >= ox && m_x < ox + 32 && m_y >= oy && m_y < oy + 32) begin
            rx = m_x - ox; ry = m_y - oy;
            cd = int'((lb[ry*8 + rx/4] >> (2*(rx%4))) & 8'h3);
            case (cd)
               0: begin ex = l_c2; tg = {"R3,R5,R6", tag_x}; end
               1: begin ex = l_c1; tg = {"R3,R5,R6", tag_x}; end
               2: begin ex = rgb;  tg = {"R3,R5,R6", tag_x}; end
               default: begin
                  ex = l_md ? l_ax : ~rgb;
                  tg = l_md ? {"R8", tag_x} : {"R7", tag_x};
               end
            endcase
         end
         m_x++;
      end
      e1v = v; e1 = ex; t1 = tg;
      in_valid = v; in_sof = sof; in_sol = sol; in_rgb = rgb;
      hw_en = we; hw_addr = 9'(wa); hw_data = wd;
      if (we) model_wr(wa, wd);
   endtask

   task automatic host(int a, logic [23:0] d);
      step(0, 0, 0, '0, 1, a, d);
   endtask

   task automatic frame(bit mid_wr);
      int cyc = 0;
      tag_x = "";
      for (int y = 0; y < 40; y++) begin
         for (int x = 0; x < 48; x++) begin
            logic [7:0] r, g, b; bit w; int wa; logic [23:0] wd;
            r = 8'(x * 5); g = 8'(y * 3); b = 8'(x ^ y);
            w = 0; wa = 0; wd = '0;
            if (mid_wr && y == 20 && x < 4) begin
               w = 1; tag_x = " R9";
               case (x)
                  0: begin wa = 256; wd = 24'd1; end
                  1: begin wa = 257; wd = 24'd0; end
                  2: begin wa = 258; wd = 24'h04_0005; end
                  default: begin wa = 262; wd = 24'd1; end
               endcase
            end
            if (cyc % 7 == 6) step(0, 0, 0, '0, 0, 0, '0);
            step(1, x == 0 && y == 0, x == 0, {r, g, b}, w, wa, wd);
            cyc++;
         end
      end
      step(0, 0, 0, '0, 0, 0, '0);
   endtask

   task automatic load_img(int mul, int add);
      for (int i = 0; i < 256; i++) host(i, 24'((i * mul + add) & 255));
   endtask

   task automatic load_cfg(int px, int py, int hx, int hy, bit md);
      host(256, 24'(px)); host(257, 24'(py)); host(258, 24'((hy << 16) | hx));
      host(262, {23'd0, md});
   endtask

   initial begin
      e1v = 0; e2v = 0; e1 = '0; e2 = '0; t1 = ""; t2 = ""; tag_x = "";
      for (int i = 0; i < 256; i++) begin bb[i] = '0; lb[i] = '0; end
      b_px = 0; b_py = 0; b_hx = 0; b_hy = 0; b_c1 = '0; b_c2 = '0; b_ax = '0; b_md = 0;
      l_px = 0; l_py = 0; l_hx = 0; l_hy = 0; l_c1 = '0; l_c2 = '0; l_ax = '0; l_md = 0;
      m_x = 0; m_y = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_valid === 1'b0 && out_rgb === 24'd0, "R1", out_rgb, 24'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0 && out_rgb === 24'd0, "R1", out_rgb, 24'd0);
      host(259, 24'h11AA22); host(260, 24'h3355CC); host(261, 24'hF0F00F);
      load_img(29, 7);
      load_cfg(10, 8, 3, 2, 0);
      frame(0);                 // mode 0, plain offset
      frame(1);                 // writes mid-frame: R9, frame keeps old setup
      frame(0);                 // clamped origin at (0,0), mode 1
      load_img(53, 91);
      load_cfg(40, 30, 0, 0, 0);
      frame(0);                 // runs past right and bottom edges
      load_cfg(31, 31, 31, 31, 1);
      frame(0);
      repeat (3) step(0, 0, 0, '0, 0, 0, '0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule